// File: doc/BRIEF.md
# Length-Prefixed Endpoint Packet Buffer

This block holds one endpoint packet and joins two views of it. A processor reaches it through 16-bit word accesses. A USB engine reaches it through a byte stream. On the processor side, every packet starts with a length word that gives the number of payload bytes. The payload words follow, and within each word the low byte comes first. If the length is odd, the last payload word carries only one valid byte.

The `dir_in` input sets the direction. In the IN direction the processor writes the length word and the payload words. Once it has written the last word, the buffer is full and streams exactly the stated number of bytes to the USB side. In the OUT direction the USB side pushes bytes one at a time and closes the packet with an end strobe. The buffer then records the byte count as the length word and is full until the processor has read the length word and every payload word. An access against the direction is refused and flagged.

Top module: `ep_pkt_buf`

## Requirements
- R1: After reset, `buf_full`, `usb_tx_valid` and `cpu_err` are 0 and `cpu_rdata` is 0.
- R2: In IN mode the first word written is the packet length in bytes. A value above MAX_BYTES is clamped to MAX_BYTES.
- R3: In IN mode payload bytes leave on `usb_tx_data` in order, with bits 7:0 of each written word first and bits 15:8 second. Data and valid stay stable while `usb_tx_ready` is low.
- R4: In IN mode exactly the clamped number of bytes is sent. For an odd length, bits 15:8 of the last written word are never sent.
- R5: In IN mode `buf_full` is 0 while payload words are still owed. It becomes 1 after the write of word ceil(len/2), or straight after the length word when the length is 0. It returns to 0 once the last byte has been accepted by the USB side.
- R6: In OUT mode, bytes taken while `usb_rx_valid` is high are stored in order. `usb_rx_end` sets `buf_full` and makes the length word, read first, equal to the byte count.
- R7: In OUT mode each payload word read returns the earlier byte in bits 7:0 and the later byte in bits 15:8. For an odd count, bits 15:8 of the last word read as 0.
- R8: In OUT mode `buf_full` stays 1 until the length word and all ceil(count/2) payload words have been read, and is 0 after the last read.
- R9: In OUT mode bytes beyond MAX_BYTES are dropped and the length word reports MAX_BYTES.
- R10: A processor write in OUT mode or read in IN mode leaves the buffer contents unchanged. During such a read `cpu_rdata` is 0. On the following cycle `cpu_err` is 1 for one cycle.
- R11: In OUT mode, bytes offered while `buf_full` is 1 are ignored and do not alter the stored packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_in | input | 1 | 1 = IN (processor writes), 0 = OUT (processor reads) |
| cpu_wr | input | 1 | Processor word write strobe |
| cpu_rd | input | 1 | Processor word read strobe; advances the word pointer |
| cpu_wdata | input | 16 | Processor write word |
| cpu_rdata | output | 16 | Current word for the processor: length word first, then payload |
| cpu_err | output | 1 | One-cycle pulse after an access against the direction |
| usb_tx_valid | output | 1 | IN byte available |
| usb_tx_data | output | 8 | IN byte |
| usb_tx_ready | input | 1 | USB side accepts the IN byte |
| usb_rx_valid | input | 1 | OUT byte offered |
| usb_rx_data | input | 8 | OUT byte |
| usb_rx_end | input | 1 | OUT packet complete |
| buf_full | output | 1 | Packet ready for the consumer side |

## Verification
The hardest cases to reach are the ones where the buffer must refuse input while it holds a complete packet. These are a stray USB byte after the end strobe, and a processor access in the wrong direction in the middle of a packet. In each case the refused input must leave no trace. The stimulus drives both of these into every packet of a sweep over all lengths from zero to beyond the maximum, in both directions. It then checks that every byte read back, or streamed out, still matches the original payload. A length word of 0xFFFF is also written to reach the clamp at its widest.

// File: rtl/ep_pkt_buf.sv
module ep_pkt_buf #(
  parameter int MAX_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir_in,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  output logic        cpu_err,
  output logic        usb_tx_valid,
  output logic [7:0]  usb_tx_data,
  input  logic        usb_tx_ready,
  input  logic        usb_rx_valid,
  input  logic [7:0]  usb_rx_data,
  input  logic        usb_rx_end,
  output logic        buf_full
);
  localparam int DEPTH = MAX_BYTES + (MAX_BYTES % 2);
  localparam int IW    = $clog2(DEPTH);
  localparam int BW    = $clog2(DEPTH + 1) + 1;
  localparam logic [BW-1:0] MAXL = BW'(MAX_BYTES);

  logic [7:0]    mem [DEPTH];
  logic [BW-1:0] bp, pkt_len;
  logic          hdr, full, err_q;

  wire [IW-1:0] lo_i = bp[IW-1:0];
  wire [IW-1:0] hi_i = {lo_i[IW-1:1], 1'b1};
  wire [BW-1:0] bp_n1 = bp + BW'(1);
  wire [BW-1:0] bp_n2 = bp + BW'(2);

  wire [15:0]   wlen    = (cpu_wdata > 16'(MAX_BYTES)) ? 16'(MAX_BYTES) : cpu_wdata;
  wire [BW-1:0] hdr_len = wlen[BW-1:0];

  wire in_wr   = dir_in && cpu_wr && !full;
  wire out_rd  = !dir_in && cpu_rd && full;
  wire tx_fire = usb_tx_valid && usb_tx_ready;
  wire rx_take = !dir_in && !full && usb_rx_valid && (bp < MAXL);
  wire rx_done = !dir_in && !full && usb_rx_end;
  wire [BW-1:0] rx_cnt = bp + BW'(rx_take);

  wire [7:0] hi_byte = (bp_n1 < pkt_len) ? mem[hi_i] : 8'h00;

  assign cpu_rdata    = (!dir_in && full) ? (hdr ? 16'(pkt_len) : {hi_byte, mem[lo_i]}) : 16'h0000;
  assign usb_tx_valid = dir_in && full && (bp < pkt_len);
  assign usb_tx_data  = mem[lo_i];
  assign buf_full     = full;
  assign cpu_err      = err_q;

  always_ff @(posedge clk) begin
    if (in_wr && !hdr) begin
      mem[lo_i] <= cpu_wdata[7:0];
      mem[hi_i] <= cpu_wdata[15:8];
    end else if (rx_take) begin
      mem[lo_i] <= usb_rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp      <= '0;
      pkt_len <= '0;
      hdr     <= 1'b1;
      full    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (cpu_wr && !dir_in) || (cpu_rd && dir_in);
      if (in_wr) begin
        if (hdr) begin
          pkt_len <= hdr_len;
          bp      <= '0;
          hdr     <= (hdr_len == '0);
          full    <= (hdr_len == '0);
        end else if (bp_n2 >= pkt_len) begin
          full <= 1'b1;
          hdr  <= 1'b1;
          bp   <= '0;
        end else begin
          bp <= bp_n2;
        end
      end else if (dir_in && full) begin
        if (pkt_len == '0) begin
          full <= 1'b0;
        end else if (tx_fire) begin
          if (bp_n1 == pkt_len) begin
            full <= 1'b0;
            bp   <= '0;
          end else begin
            bp <= bp_n1;
          end
        end
      end else if (rx_done) begin
        pkt_len <= rx_cnt;
        full    <= 1'b1;
        hdr     <= 1'b1;
        bp      <= '0;
      end else if (rx_take) begin
        bp <= bp_n1;
      end else if (out_rd) begin
        if (hdr) begin
          bp <= '0;
          if (pkt_len == '0) full <= 1'b0;
          else hdr <= 1'b0;
        end else if (bp_n2 >= pkt_len) begin
          full <= 1'b0;
          hdr  <= 1'b1;
          bp   <= '0;
        end else begin
          bp <= bp_n2;
        end
      end
    end
  end
endmodule

module ep_pkt_buf_chk #(
  parameter int MAX_BYTES = 64,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_in,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic          cpu_err,
  input logic          usb_tx_valid,
  input logic [7:0]    usb_tx_data,
  input logic          usb_tx_ready,
  input logic          usb_rx_end,
  input logic          buf_full,
  input logic [BW-1:0] pkt_len
);
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_tx_valid && !usb_tx_ready) |=> (usb_tx_valid && $stable(usb_tx_data)));

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_wr && !dir_in) || (cpu_rd && dir_in)) |=> cpu_err);

  a_r6_end_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && !buf_full && usb_rx_end) |=> buf_full);

  a_r11_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && buf_full && !cpu_rd && $stable(dir_in)) |=> buf_full);

  a_r9_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> (pkt_len <= BW'(MAX_BYTES)));

  a_r5_tx_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_tx_valid) |-> buf_full);
endmodule

bind ep_pkt_buf ep_pkt_buf_chk #(.MAX_BYTES(MAX_BYTES), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_err(cpu_err), .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data),
  .usb_tx_ready(usb_tx_ready), .usb_rx_end(usb_rx_end), .buf_full(buf_full),
  .pkt_len(pkt_len)
);

// File: tb/ep_pkt_buf_tb_top.sv
module ep_pkt_buf_tb_top;
  localparam int MAXB = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_in = 1'b1, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic cpu_err, usb_tx_valid, buf_full;
  logic [7:0] usb_tx_data;
  logic usb_tx_ready = 1'b0, usb_rx_valid = 1'b0, usb_rx_end = 1'b0;
  logic [7:0] usb_rx_data = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ep_pkt_buf #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
    .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data), .usb_tx_ready(usb_tx_ready),
    .usb_rx_valid(usb_rx_valid), .usb_rx_data(usb_rx_data), .usb_rx_end(usb_rx_end),
    .buf_full(buf_full)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'(seed * 31 + i * 13 + 5);
  endfunction

  task automatic in_pkt(input int len, input int seed);
    int le = (len > MAXB) ? MAXB : len;
    int nw = (le + 1) / 2;
    int cnt = 0;
    cpu_wr = 1'b1; cpu_wdata = 16'(len);
    @(negedge clk);
    cpu_wr = 1'b0;
    if (le > 0) chk(buf_full == 1'b0, "R5 not full before payload", int'(buf_full), 0);
    for (int k = 0; k < nw; k++) begin
      cpu_wr = 1'b1;
      cpu_wdata = {bval(seed, 2*k+1), bval(seed, 2*k)};
      @(negedge clk);
    end
    cpu_wr = 1'b0;
    chk(buf_full == 1'b1, "R5 full after last word", int'(buf_full), 1);
    chk(usb_tx_valid == (le > 0), "R4 tx valid on full", int'(usb_tx_valid), int'(le > 0));
    if (le > 0) begin
      cpu_rd = 1'b1;
      #0 chk(cpu_rdata == 16'h0, "R10 illegal read returns zero", int'(cpu_rdata), 0);
      @(negedge clk);
      cpu_rd = 1'b0;
      chk(cpu_err == 1'b1, "R10 err after illegal read", int'(cpu_err), 1);
    end
    for (int c = 0; c < 3*le + 4; c++) begin
      usb_tx_ready = (c % 3) != 1;
      #0;
      if (usb_tx_valid && usb_tx_ready) begin
        chk(usb_tx_data == bval(seed, cnt), "R3 tx byte order", int'(usb_tx_data), int'(bval(seed, cnt)));
        cnt++;
      end
      @(negedge clk);
    end
    usb_tx_ready = 1'b0;
    chk(cnt == le, "R4 R2 tx byte count", cnt, le);
    chk(buf_full == 1'b0, "R5 full clears after send", int'(buf_full), 0);
  endtask

  task automatic out_pkt(input int n, input int seed);
    int le = (n > MAXB) ? MAXB : n;
    int nw = (le + 1) / 2;
    for (int i = 0; i < n; i++) begin
      usb_rx_valid = 1'b1; usb_rx_data = bval(seed, i);
      @(negedge clk);
    end
    usb_rx_valid = 1'b0; usb_rx_end = 1'b1;
    @(negedge clk);
    usb_rx_end = 1'b0;
    chk(buf_full == 1'b1, "R6 full after end", int'(buf_full), 1);
    usb_rx_valid = 1'b1; usb_rx_data = 8'hEE;
    @(negedge clk);
    usb_rx_valid = 1'b0;
    cpu_wr = 1'b1; cpu_wdata = 16'hBEEF;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk(cpu_err == 1'b1, "R10 err after illegal write", int'(cpu_err), 1);
    chk(cpu_rdata == 16'(le), "R6 R9 R11 length word", int'(cpu_rdata), le);
    cpu_rd = 1'b1;
    @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      logic [7:0] lo = bval(seed, 2*k);
      logic [7:0] hi = (2*k + 1 < le) ? bval(seed, 2*k+1) : 8'h00;
      chk(buf_full == 1'b1, "R8 full until last word", int'(buf_full), 1);
      chk(cpu_rdata == {hi, lo}, "R7 R11 payload word", int'(cpu_rdata), int'({hi, lo}));
      @(negedge clk);
    end
    cpu_rd = 1'b0;
    chk(buf_full == 1'b0, "R8 full clears after read", int'(buf_full), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    chk(buf_full == 1'b0, "R1 reset full", int'(buf_full), 0);
    chk(usb_tx_valid == 1'b0, "R1 reset tx valid", int'(usb_tx_valid), 0);
    chk(cpu_err == 1'b0, "R1 reset err", int'(cpu_err), 0);
    chk(cpu_rdata == 16'h0, "R1 reset rdata", int'(cpu_rdata), 0);
    dir_in = 1'b1;
    @(negedge clk);
    for (int l = 0; l <= MAXB + 3; l++) in_pkt(l, l + 1);
    in_pkt(16'hFFFF, 42);
    dir_in = 1'b0;
    @(negedge clk);
    for (int n = 0; n <= MAXB + 3; n++) out_pkt(n, n + 7);
    dir_in = 1'b1;
    @(negedge clk);
    in_pkt(5, 99);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule